// File: doc/BRIEF.md
# Card Host Status and Interrupt Register

This block holds the event status of a memory-card host controller and turns it into one level interrupt. Pulses from the command and data engines set individual status bits. Software reads the status word over a small synchronous register bus and clears bits by writing ones to them. A 15-bit enable mask selects which status bits raise the interrupt line.

The block also keeps the controller-enable bit. While that bit is clear, command writes are refused. When a command write is accepted, the block zeroes the eight 16-bit response words before the protocol engine refills them. A card-detect input is synchronised inside the block. Its rising edge is reported as a card-inserted event, and its synchronised level drives a cover-switch output. A soft reset can come from the control word or from the system-config word. It clears status, mask, command and response state and sends a one-cycle flush pulse to the transfer counters and the FIFO.

Top module: `cardhost_stat_irq`

## Requirements
- R1: `irq` is high exactly when the status word AND the mask word is non-zero. It changes right after the clock edge that updates either register, with no further delay, and it cannot rise without an event or a mask write.
- R2: A write to the status word (address 2) clears each bit where the written value is 1. Bits written as 0 are kept.
- R3: A write to the mask word (address 3) keeps only bits 14..0. Mask bit 15 always reads 0.
- R4: On a command-finished pulse, a timeout sets only bit 7. Otherwise bit 0 is set. If the low 6 bits of the last accepted command word equal 12, bit 2 is set as well. If the error qualifier is also given on a finish without timeout, bit 14 is set too.
- R5: The block-end pulse sets bit 3, the receive-threshold pulse sets bit 10 and the transmit-threshold pulse sets bit 11.
- R6: An event that arrives in the same cycle as a status clear wins, so its bit ends up set.
- R7: After `card_det` changes, `cover_sw` follows it after SYNC_STAGES clock edges. A 0-to-1 change also sets status bit 1 one edge later. A 1-to-0 change sets no status bit.
- R8: A write to the command word (address 0) is ignored while the enable bit (bit 0 of address 1) is clear. No `cmd_issue` pulse is produced and the stored command word is unchanged.
- R9: An accepted command write stores the word, drives `cmd_issue` high for one cycle, and zeroes all eight response words (addresses 8..15) in that same cycle.
- R10: A soft reset is a write of 0 to control bit 0, or a write with bit 2 set to the system-config word (address 4). It zeroes status, mask, enable, command and response words, and it overrides events in the same cycle. It pulses `xfer_flush` for one cycle. A system-config write with bit 2 clear has no effect.
- R11: `bus_rdata` takes the addressed word on the clock edge that samples `bus_rd`. Address 1 reads back the enable bit, address 4 and unmapped addresses read 0, and addresses 8..15 read response words 0..7 as loaded through `rsp_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| evt_cmd_fin | input | 1 | Command finished pulse |
| evt_cmd_tmo | input | 1 | Timeout qualifier for the finish pulse |
| evt_rsp_err | input | 1 | Response error qualifier for the finish pulse |
| evt_blk_end | input | 1 | End of block transfer pulse |
| evt_rx_thr | input | 1 | Receive FIFO threshold pulse |
| evt_tx_thr | input | 1 | Transmit FIFO threshold pulse |
| rsp_we | input | 1 | Response word load strobe |
| rsp_idx | input | 3 | Response word index |
| rsp_data | input | 16 | Response word value |
| card_det | input | 1 | Asynchronous card-detect level |
| cover_sw | output | 1 | Synchronised card-detect level |
| cmd_issue | output | 1 | One-cycle pulse on an accepted command |
| cmd_word | output | 16 | Last accepted command word |
| xfer_flush | output | 1 | One-cycle flush pulse after a soft reset |
| irq | output | 1 | Level interrupt |

## Verification
Register writes and event pulses are driven on a falling edge. Their effect is stored on the next rising edge, so status, mask and `irq` are checked on the falling edge that follows. A read needs one rising edge to capture the word, and `bus_rdata` is sampled on the falling edge after that edge. After a card-detect change, the bench checks `cover_sw` at the falling edges after edge one and edge two, and checks the inserted bit through `irq` one edge later. `cmd_issue` and `xfer_flush` are counted on falling edges, so each one-cycle pulse is seen exactly once.

// File: rtl/chst_pkg.sv
// Package: shared constants for the card host status block.
// Holds register widths, status bit positions and word addresses.
package chst_pkg;
    localparam int REG_W        = 16;
    localparam int MASK_BITS    = 15;
    localparam int CMD_IDX_W    = 6;

    // status bit positions
    localparam int ST_CMD_END   = 0;
    localparam int ST_CARD_IN   = 1;
    localparam int ST_BUSY_END  = 2;
    localparam int ST_BLK_END   = 3;
    localparam int ST_CMD_TMO   = 7;
    localparam int ST_RX_THR    = 10;
    localparam int ST_TX_THR    = 11;
    localparam int ST_RSP_ERR   = 14;

    // system-config soft reset bit, control enable bit
    localparam int SYS_SRST_BIT = 2;
    localparam int CTL_EN_BIT   = 0;

    // word addresses
    localparam int A_CMD        = 0;
    localparam int A_CTRL       = 1;
    localparam int A_STAT       = 2;
    localparam int A_MASK       = 3;
    localparam int A_SYS        = 4;
    localparam int A_RSP_BASE   = 8;
endpackage

// File: rtl/chst_card_detect.sv
// Module: chst_card_detect
// Synchronises the card-detect level through SYNC_STAGES flops.
// Drives the synchronised level out as the cover switch and flags
// each rising edge for one cycle.
// Assumes card_det may change at any time relative to clk.
module chst_card_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_det,
    output logic level,
    output logic insert_pulse
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   seen_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // first synchroniser stage samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= card_det;
            end
        end else begin : g_next
            // later stages shift the level along
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign level = chain[SYNC_STAGES-1];

    // remember last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= level;
    end

    assign insert_pulse = level & ~seen_q;
endmodule

// File: rtl/chst_event_map.sv
// Module: chst_event_map
// Turns the raw event pulses into a vector of status bits to set.
// Uses the index of the last accepted command to spot a stop
// command. Pure combinational logic.
module chst_event_map
    import chst_pkg::*;
#(
    parameter int STOP_IDX = 12
) (
    input  logic                 evt_cmd_fin,
    input  logic                 evt_cmd_tmo,
    input  logic                 evt_rsp_err,
    input  logic                 evt_blk_end,
    input  logic                 evt_rx_thr,
    input  logic                 evt_tx_thr,
    input  logic                 card_insert,
    input  logic [CMD_IDX_W-1:0] cmd_index,
    output logic [REG_W-1:0]     set_vec
);
    logic fin_ok;
    logic is_stop;

    assign fin_ok  = evt_cmd_fin & ~evt_cmd_tmo;
    assign is_stop = (cmd_index == CMD_IDX_W'(STOP_IDX));

    // build the per-bit set vector
    always_comb begin
        set_vec              = '0;
        set_vec[ST_CMD_END]  = fin_ok;
        set_vec[ST_BUSY_END] = fin_ok & is_stop;
        set_vec[ST_CMD_TMO]  = evt_cmd_fin & evt_cmd_tmo;
        set_vec[ST_RSP_ERR]  = fin_ok & evt_rsp_err;
        set_vec[ST_CARD_IN]  = card_insert;
        set_vec[ST_BLK_END]  = evt_blk_end;
        set_vec[ST_RX_THR]   = evt_rx_thr;
        set_vec[ST_TX_THR]   = evt_tx_thr;
    end
endmodule

// File: rtl/chst_status.sv
// Module: chst_status
// Holds the status and mask words and drives the level interrupt.
// A software clear uses write-one-to-clear, and same-cycle events win.
// A soft reset zeroes both words and wins over everything else.
module chst_status #(
    parameter int REG_W     = 16,
    parameter int MASK_BITS = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             w1c_en,
    input  logic             mask_we,
    input  logic [REG_W-1:0] wval,
    input  logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] mask,
    output logic             irq
);
    localparam logic [REG_W-1:0] MASK_KEEP = REG_W'((64'd1 << MASK_BITS) - 64'd1);

    logic [REG_W-1:0] clr_bits;

    assign clr_bits = w1c_en ? wval : '0;

    // status word: clear by ones, then merge new events
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) stat <= '0;
        else                   stat <= (stat & ~clr_bits) | set_vec;
    end

    // mask word: only the implemented bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) mask <= '0;
        else if (mask_we)      mask <= wval & MASK_KEEP;
    end

    assign irq = |(stat & mask);
endmodule

// File: rtl/chst_cmd_regs.sv
// Module: chst_cmd_regs
// Holds the enable bit, the last accepted command word and the
// response words. A command is refused while the enable bit is clear.
// An accepted command zeroes every response word.
module chst_cmd_regs #(
    parameter int REG_W     = 16,
    parameter int RSP_WORDS = 8,
    parameter int RSP_IDX_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_all,
    input  logic                       ctrl_we,
    input  logic                       ctrl_en_bit,
    input  logic                       cmd_we,
    input  logic [REG_W-1:0]           cmd_wdata,
    input  logic                       rsp_we,
    input  logic [RSP_IDX_W-1:0]       rsp_idx,
    input  logic [REG_W-1:0]           rsp_data,
    output logic                       enable,
    output logic [REG_W-1:0]           cmd_word,
    output logic                       cmd_issue,
    output logic [RSP_WORDS*REG_W-1:0] rsp_flat
);
    logic [REG_W-1:0] rsp_q [RSP_WORDS];
    logic             accept;

    assign accept = cmd_we & enable;

    // controller enable bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) enable <= 1'b0;
        else if (ctrl_we)      enable <= ctrl_en_bit;
    end

    // command word and issue pulse
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            cmd_word  <= '0;
            cmd_issue <= 1'b0;
        end else begin
            cmd_issue <= accept;
            if (accept) cmd_word <= cmd_wdata;
        end
    end

    // response words: zeroed on accept, else loaded by the engine
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all || accept) begin
            for (int i = 0; i < RSP_WORDS; i++) rsp_q[i] <= '0;
        end else if (rsp_we && (int'(rsp_idx) < RSP_WORDS)) begin
            rsp_q[rsp_idx] <= rsp_data;
        end
    end

    for (genvar g = 0; g < RSP_WORDS; g++) begin : g_flat
        assign rsp_flat[g*REG_W +: REG_W] = rsp_q[g];
    end
endmodule

// File: rtl/cardhost_stat_irq.sv
// Module: cardhost_stat_irq
// Top of the card host status block. Decodes the register bus,
// combines the status, command and card-detect pieces, and
// registers read data one cycle after the strobe.
// Assumes single-cycle bus strobes and word addressing.
module cardhost_stat_irq
    import chst_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int RSP_WORDS   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STOP_IDX    = 12,
    localparam int RSP_IDX_W  = (RSP_WORDS > 1) ? $clog2(RSP_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic                 evt_cmd_fin,
    input  logic                 evt_cmd_tmo,
    input  logic                 evt_rsp_err,
    input  logic                 evt_blk_end,
    input  logic                 evt_rx_thr,
    input  logic                 evt_tx_thr,
    input  logic                 rsp_we,
    input  logic [RSP_IDX_W-1:0] rsp_idx,
    input  logic [REG_W-1:0]     rsp_data,
    input  logic                 card_det,
    output logic                 cover_sw,
    output logic                 cmd_issue,
    output logic [REG_W-1:0]     cmd_word,
    output logic                 xfer_flush,
    output logic                 irq
);
    logic                       wr_cmd, wr_ctrl, wr_stat, wr_mask, wr_sys;
    logic                       clr_all;
    logic                       in_rsp;
    logic [RSP_IDX_W-1:0]       rsp_sel;
    logic [REG_W-1:0]           stat_w, mask_w, set_vec, rd_next;
    logic [RSP_WORDS*REG_W-1:0] rsp_flat;
    logic                       enable_w;
    logic                       card_insert;

    // write decode
    assign wr_cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));
    assign wr_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK));
    assign wr_sys  = bus_wr && (bus_addr == ADDR_W'(A_SYS));

    assign clr_all = (wr_ctrl && !bus_wdata[CTL_EN_BIT]) ||
                     (wr_sys  &&  bus_wdata[SYS_SRST_BIT]);

    assign in_rsp  = (int'(bus_addr) >= A_RSP_BASE) &&
                     (int'(bus_addr) <  A_RSP_BASE + RSP_WORDS);
    assign rsp_sel = RSP_IDX_W'(int'(bus_addr) - A_RSP_BASE);

    chst_card_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cdet (
        .clk          (clk),
        .rst_n        (rst_n),
        .card_det     (card_det),
        .level        (cover_sw),
        .insert_pulse (card_insert)
    );

    chst_event_map #(.STOP_IDX(STOP_IDX)) u_emap (
        .evt_cmd_fin (evt_cmd_fin),
        .evt_cmd_tmo (evt_cmd_tmo),
        .evt_rsp_err (evt_rsp_err),
        .evt_blk_end (evt_blk_end),
        .evt_rx_thr  (evt_rx_thr),
        .evt_tx_thr  (evt_tx_thr),
        .card_insert (card_insert),
        .cmd_index   (cmd_word[CMD_IDX_W-1:0]),
        .set_vec     (set_vec)
    );

    chst_status #(.REG_W(REG_W), .MASK_BITS(MASK_BITS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .w1c_en  (wr_stat),
        .mask_we (wr_mask),
        .wval    (bus_wdata),
        .set_vec (set_vec),
        .stat    (stat_w),
        .mask    (mask_w),
        .irq     (irq)
    );

    chst_cmd_regs #(.REG_W(REG_W), .RSP_WORDS(RSP_WORDS), .RSP_IDX_W(RSP_IDX_W)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all     (clr_all),
        .ctrl_we     (wr_ctrl),
        .ctrl_en_bit (bus_wdata[CTL_EN_BIT]),
        .cmd_we      (wr_cmd),
        .cmd_wdata   (bus_wdata),
        .rsp_we      (rsp_we),
        .rsp_idx     (rsp_idx),
        .rsp_data    (rsp_data),
        .enable      (enable_w),
        .cmd_word    (cmd_word),
        .cmd_issue   (cmd_issue),
        .rsp_flat    (rsp_flat)
    );

    // read multiplexer
    always_comb begin
        rd_next = '0;
        if (in_rsp) rd_next = rsp_flat[rsp_sel*REG_W +: REG_W];
        else if (bus_addr == ADDR_W'(A_CMD))  rd_next = cmd_word;
        else if (bus_addr == ADDR_W'(A_CTRL)) rd_next = REG_W'(enable_w);
        else if (bus_addr == ADDR_W'(A_STAT)) rd_next = stat_w;
        else if (bus_addr == ADDR_W'(A_MASK)) rd_next = mask_w;
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // one-cycle flush pulse to counters and FIFO
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_flush <= 1'b0;
        else        xfer_flush <= clr_all;
    end
endmodule

// File: rtl/chst_checker.sv
// Module: chst_checker
// Temporal checks on the card host status block. It is attached to
// the top module by the bind statement at the end of this file.
module chst_checker #(
    parameter int REG_W     = 16,
    parameter int RSP_WORDS = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [REG_W-1:0]           stat,
    input logic [REG_W-1:0]           mask,
    input logic [REG_W-1:0]           set_vec,
    input logic [REG_W-1:0]           wdata,
    input logic                       wr_stat,
    input logic                       wr_mask,
    input logic                       wr_cmd,
    input logic                       clr_all,
    input logic                       enable,
    input logic                       cmd_issue,
    input logic [RSP_WORDS*REG_W-1:0] rsp_flat,
    input logic                       cover_sw,
    input logic                       irq
);
    // R1: no event and no mask write means irq cannot rise
    assert_irq_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && set_vec == '0 && !wr_mask && !clr_all) |=> !irq);

    // R2: bits written as one are gone when no event competes
    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && set_vec == '0 && !clr_all) |=> ((stat & $past(wdata)) == '0));

    // R3: top mask bit never stored
    assert_mask_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mask[REG_W-1] == 1'b0);

    // R6: every pending event bit is set on the next cycle
    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0 && !clr_all) |=> ((stat & $past(set_vec)) == $past(set_vec)));

    // R7: a rising cover switch reports insertion
    assert_card_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cover_sw) && !clr_all) |=> stat[1]);

    // R8: refused command gives no issue pulse
    assert_cmd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !enable) |=> !cmd_issue);

    // R9: response words are empty while the issue pulse is high
    assert_rsp_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> (rsp_flat == '0));

    // R10: a soft reset empties status, mask and enable
    assert_soft_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (stat == '0 && mask == '0 && !enable && !irq));
endmodule

bind cardhost_stat_irq chst_checker #(.REG_W(16), .RSP_WORDS(RSP_WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat      (stat_w),
    .mask      (mask_w),
    .set_vec   (set_vec),
    .wdata     (bus_wdata),
    .wr_stat   (wr_stat),
    .wr_mask   (wr_mask),
    .wr_cmd    (wr_cmd),
    .clr_all   (clr_all),
    .enable    (enable_w),
    .cmd_issue (cmd_issue),
    .rsp_flat  (rsp_flat),
    .cover_sw  (cover_sw),
    .irq       (irq)
);

// File: tb/sim_cardhost_stat_irq.sv
// Bench for cardhost_stat_irq: sweeps status, mask and event patterns
// and computes the expected words from the requirements.
module sim_cardhost_stat_irq;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        evt_cmd_fin = 0, evt_cmd_tmo = 0, evt_rsp_err = 0;
    logic        evt_blk_end = 0, evt_rx_thr = 0, evt_tx_thr = 0;
    logic        rsp_we = 0;
    logic [2:0]  rsp_idx = '0;
    logic [15:0] rsp_data = '0;
    logic        card_det = 0;
    logic        cover_sw, cmd_issue, xfer_flush, irq;
    logic [15:0] cmd_word;

    int n_chk = 0, n_fail = 0, n_issue = 0, n_flush = 0;
    logic [15:0] rd;

    always #4 clk = ~clk;

    cardhost_stat_irq #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_cmd_fin(evt_cmd_fin), .evt_cmd_tmo(evt_cmd_tmo),
        .evt_rsp_err(evt_rsp_err), .evt_blk_end(evt_blk_end),
        .evt_rx_thr(evt_rx_thr), .evt_tx_thr(evt_tx_thr),
        .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
        .card_det(card_det), .cover_sw(cover_sw), .cmd_issue(cmd_issue),
        .cmd_word(cmd_word), .xfer_flush(xfer_flush), .irq(irq)
    );

    // count one-cycle pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_issue)  n_issue++;
            if (xfer_flush) n_flush++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rdw(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    // events: bit0 fin, 1 tmo, 2 err, 3 blk, 4 rx, 5 tx
    task automatic drive_ev(input logic [5:0] e);
        {evt_tx_thr, evt_rx_thr, evt_blk_end, evt_rsp_err, evt_cmd_tmo, evt_cmd_fin} = e;
    endtask

    task automatic fire(input logic [5:0] e);
        @(negedge clk); drive_ev(e);
        @(negedge clk); drive_ev('0);
    endtask

    function automatic logic [15:0] exp_bits(input logic [5:0] e, input logic [15:0] cmd);
        logic [15:0] r = '0;
        if (e[0]) begin
            if (e[1]) r[7] = 1;
            else begin
                r[0] = 1;
                if (cmd[5:0] == 6'd12) r[2] = 1;
                if (e[2]) r[14] = 1;
            end
        end
        if (e[3]) r[3]  = 1;
        if (e[4]) r[10] = 1;
        if (e[5]) r[11] = 1;
        return r;
    endfunction

    task automatic issue(input logic [15:0] c);
        wr(4'd0, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        rdw(4'd2, rd); chk("R11 reset stat", rd, 16'h0);
        rdw(4'd3, rd); chk("R11 reset mask", rd, 16'h0);
        rdw(4'd0, rd); chk("R11 reset cmd", rd, 16'h0);
        rdw(4'd1, rd); chk("R11 reset ctrl", rd, 16'h0);
        chk("R1 reset irq", irq, 0);
        chk("R7 reset cover", cover_sw, 0);

        // R3 mask width
        wr(4'd3, 16'hFFFF); rdw(4'd3, rd); chk("R3 mask keep", rd, 16'h7FFF);
        wr(4'd3, 16'h8000); rdw(4'd3, rd); chk("R3 mask bit15", rd, 16'h0000);

        // R8 command while disabled
        base = n_issue;
        issue(16'h0012); @(negedge clk);
        chk("R8 no issue", n_issue - base, 0);
        rdw(4'd0, rd); chk("R8 cmd kept", rd, 16'h0);

        // R11 response load and read
        wr(4'd1, 16'h0001); rdw(4'd1, rd); chk("R11 ctrl enable", rd, 16'h1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rsp_we = 1; rsp_idx = 3'(i); rsp_data = 16'(16'h1111 * (i + 1));
            @(negedge clk); rsp_we = 0;
        end
        for (int i = 0; i < 8; i++) begin
            rdw(4'(8 + i), rd); chk("R11 rsp read", rd, 16'(16'h1111 * (i + 1)));
        end
        rdw(4'd4, rd); chk("R11 sys reads 0", rd, 16'h0);
        rdw(4'd5, rd); chk("R11 unmapped 0", rd, 16'h0);

        // R9 accepted command
        base = n_issue;
        issue(16'h0005); @(negedge clk);
        chk("R9 issue pulse", n_issue - base, 1);
        chk("R9 cmd_word", cmd_word, 16'h0005);
        for (int i = 0; i < 8; i++) begin
            rdw(4'(8 + i), rd); chk("R9 rsp zero", rd, 16'h0);
        end

        // R4 completion encodings
        begin
            logic [15:0] cmds [4] = '{16'h0011, 16'h000C, 16'h004C, 16'h0001};
            logic [5:0]  evs  [4] = '{6'b000001, 6'b000011, 6'b000101, 6'b000111};
            foreach (cmds[c]) begin
                issue(cmds[c]);
                foreach (evs[e]) begin
                    fire(evs[e]);
                    rdw(4'd2, rd);
                    chk("R4 completion", rd, exp_bits(evs[e], cmds[c]));
                    wr(4'd2, 16'hFFFF);
                end
            end
        end

        // R5 data events
        issue(16'h0011);
        fire(6'b001000); rdw(4'd2, rd); chk("R5 blk end", rd, 16'h0008); wr(4'd2, 16'hFFFF);
        fire(6'b010000); rdw(4'd2, rd); chk("R5 rx thr", rd, 16'h0400); wr(4'd2, 16'hFFFF);
        fire(6'b100000); rdw(4'd2, rd); chk("R5 tx thr", rd, 16'h0800); wr(4'd2, 16'hFFFF);

        // R2 clear sweep
        for (int i = 0; i < 16; i++) begin
            fire(6'b111101); fire(6'b000011);
            wr(4'd2, 16'(1 << i));
            rdw(4'd2, rd); chk("R2 w1c single", rd, 16'h4C89 & ~16'(1 << i));
            wr(4'd2, 16'hFFFF);
        end
        rdw(4'd2, rd); chk("R2 all cleared", rd, 16'h0);

        // R1 irq sweep over event kinds and mask bits
        begin
            logic [5:0] kinds [6] = '{6'b000001, 6'b000011, 6'b000101, 6'b001000, 6'b010000, 6'b100000};
            foreach (kinds[k]) begin
                for (int m = 0; m < 16; m++) begin
                    logic [15:0] eb;
                    eb = exp_bits(kinds[k], 16'h0011);
                    wr(4'd3, 16'(1 << m));
                    fire(kinds[k]);
                    chk("R1 irq level", irq, ((eb & 16'(1 << m) & 16'h7FFF) != 0));
                    wr(4'd2, 16'hFFFF);
                    chk("R1 irq after clear", irq, 0);
                end
            end
            wr(4'd3, 16'h0);
        end

        // R6 event against same-cycle clear
        @(negedge clk); bus_wr = 1; bus_addr = 4'd2; bus_wdata = 16'hFFFF; drive_ev(6'b001000);
        @(negedge clk); bus_wr = 0; drive_ev('0);
        rdw(4'd2, rd); chk("R6 event wins", rd, 16'h0008);
        fire(6'b010000);
        @(negedge clk); bus_wr = 1; bus_addr = 4'd2; bus_wdata = 16'h0400; drive_ev(6'b100000);
        @(negedge clk); bus_wr = 0; drive_ev('0);
        rdw(4'd2, rd); chk("R6 mixed", rd, 16'h0808);
        wr(4'd2, 16'hFFFF);

        // R7 card detect timing
        wr(4'd3, 16'h0002);
        @(negedge clk); card_det = 1;
        for (int k = 1; k <= SYNC + 1; k++) begin
            @(negedge clk);
            chk("R7 cover timing", cover_sw, (k >= SYNC));
            chk("R7 insert timing", irq, (k >= SYNC + 1));
        end
        rdw(4'd2, rd); chk("R7 insert bit", rd, 16'h0002);
        wr(4'd2, 16'hFFFF);
        card_det = 0;
        repeat (SYNC + 3) @(negedge clk);
        chk("R7 cover low", cover_sw, 0);
        rdw(4'd2, rd); chk("R7 removal sets nothing", rd, 16'h0);

        // R10 soft reset paths
        wr(4'd3, 16'h7FFF); fire(6'b001000);
        base = n_flush;
        wr(4'd4, 16'hFFFB); @(negedge clk);
        chk("R10 sys no srst flush", n_flush - base, 0);
        rdw(4'd2, rd); chk("R10 sys no srst stat", rd, 16'h0008);
        @(negedge clk); bus_wr = 1; bus_addr = 4'd4; bus_wdata = 16'h0004; drive_ev(6'b010000);
        @(negedge clk); bus_wr = 0; drive_ev('0);
        @(negedge clk);
        chk("R10 flush pulse", n_flush - base, 1);
        chk("R10 irq low", irq, 0);
        rdw(4'd2, rd); chk("R10 stat zero", rd, 16'h0);
        rdw(4'd3, rd); chk("R10 mask zero", rd, 16'h0);
        rdw(4'd1, rd); chk("R10 enable zero", rd, 16'h0);
        rdw(4'd0, rd); chk("R10 cmd zero", rd, 16'h0);
        wr(4'd1, 16'h0001); wr(4'd3, 16'h0008); fire(6'b001000);
        chk("R10 irq before ctrl clear", irq, 1);
        base = n_flush;
        wr(4'd1, 16'h0000); @(negedge clk);
        chk("R10 ctrl flush", n_flush - base, 1);
        rdw(4'd2, rd); chk("R10 ctrl stat zero", rd, 16'h0);
        base = n_issue;
        issue(16'h0003); @(negedge clk);
        chk("R8 disabled after clear", n_issue - base, 0);

        summary();
        $finish;
    end
endmodule